// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous host to an external asynchronous static RAM built from four 8-bit byte lanes. The lanes share one word address bus and one output enable. Each lane has its own chip enable and its own write enable. The host starts an access with a single-cycle request that carries an address, 32-bit write data, a byte mask, a write flag and an organisation select. The controller then runs the strobe sequence using phase lengths counted in clock cycles, and it answers with a one-cycle acknowledge.

The memory can be treated as a 32-bit, 16-bit or 8-bit wide array. In the narrower organisations, the low host address bits choose a lane pair or a single lane. Write data comes from the low bits of the host word and is copied onto every lane. Read data is returned right-justified.

Each phase length is a parameter. Set it by rounding the nanosecond limit of the memory up to whole clock periods. The defaults suit a 4 ns clock with a memory that needs a 13 ns write pulse, a 17 ns access and a 12 ns release time.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During reset and after reset is released, all chip enables, write enables and the output enable are high, no lane data driver is enabled, and acknowledge is low.
- R2: A write holds the chip enables of its selected lanes low with write enable high for SETUP_CYC cycles. It then drives write enable low on the same lanes for WE_CYC cycles. Chip enable and write enable then rise in the same cycle, and acknowledge is high in that cycle for one cycle only.
- R3: The data driver of a lane is enabled exactly in the cycles where that lane's write enable is low. It is released in the cycle where write enable rises.
- R4: A read holds the selected chip enables and the output enable low, with all write enables high, for READ_CYC cycles. It samples the data bus in the last of those cycles. In the next cycle, acknowledge is high and rdata_o holds the result.
- R5: No lane driver is enabled within TURN_CYC cycles after the last cycle in which the output enable was low.
- R6: Organisation 2'b00 (32-bit): the word address is addr_i[16:0]. be_i bit n enables lane n, which carries data bits [8n+7:8n].
- R7: Organisation 2'b01 (16-bit): the word address is addr_i[17:1]. addr_i[0]=1 selects lanes 3..2 and addr_i[0]=0 selects lanes 1..0, each enabled by be_i[1:0]. wdata_i[15:0] is driven on both lane pairs. A read returns the selected pair in rdata_o[15:0] with the upper half zero.
- R8: Organisation 2'b10, and also 2'b11 (8-bit): the word address is addr_i[18:2]. addr_i[1:0] selects the lane, enabled by be_i[0]. wdata_i[7:0] is driven on every lane. A read returns the byte in rdata_o[7:0] with the rest zero.
- R9: A lane that is not enabled keeps its chip enable high for the whole access. Its byte position in rdata_o reads as zero. An access with no enabled lane writes nothing and still acknowledges.
- R10: A request that arrives while an access is in progress is ignored. It produces no acknowledge and does not change the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Single-cycle access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| org_i | input | 2 | Organisation: 00 x32, 01 x16, 10/11 x8 |
| addr_i | input | 19 | Host address in units of the organisation |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with ack_o after a read |
| mem_addr_o | output | 17 | Shared word address to the memory |
| mem_ce_no | output | 4 | Per-lane chip enable, active low |
| mem_we_no | output | 4 | Per-lane write enable, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Write data toward the memory |
| mem_dq_oe_o | output | 4 | Per-lane data driver enable |
| mem_dq_i | input | 32 | Data from the memory |

## Verification
The hardest condition to reach is a write that starts while the bus is still inside the release window of the previous read. That needs a write request in the same cycle as the read acknowledge. The stimulus table therefore issues every access as soon as the previous acknowledge is seen, and places a write directly after a read. A monitor measures the idle gap before each driver turn-on. Ignored requests are produced by pulsing a conflicting write in the middle of a read. The bench then counts acknowledges and reads the word back.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ORG_X32 = 2'b00,
    ORG_X16 = 2'b01,
    ORG_X8  = 2'b10
  } org_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_WSET,
    PH_WSTB,
    PH_RD
  } phase_e;

endpackage

// File: rtl/sram_addr_map.sv
module sram_addr_map
  import sram_lane_pkg::*;
#(
  parameter int AW     = 17,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W = $clog2(LANES),
  localparam int HAW   = AW + SEL_W,
  localparam int DW    = LANES * LANE_W,
  localparam int HALF  = LANES / 2
) (
  input  logic [1:0]       org_i,
  input  logic [HAW-1:0]   haddr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [AW-1:0]    waddr_o,
  output logic [LANES-1:0] mask_o,
  output logic [DW-1:0]    wlanes_o,
  output logic [SEL_W-1:0] sel_o
);

  always_comb begin
    case (org_i)
      ORG_X32: begin
        waddr_o  = haddr_i[AW-1:0];
        mask_o   = be_i;
        wlanes_o = wdata_i;
        sel_o    = '0;
      end
      ORG_X16: begin
        waddr_o  = haddr_i[AW:1];
        mask_o   = haddr_i[0] ? {be_i[HALF-1:0], {HALF{1'b0}}}
                              : {{HALF{1'b0}}, be_i[HALF-1:0]};
        wlanes_o = {2{wdata_i[DW/2-1:0]}};
        sel_o    = SEL_W'(haddr_i[0]);
      end
      default: begin
        waddr_o  = haddr_i[AW+SEL_W-1:SEL_W];
        mask_o   = LANES'(be_i[0]) << haddr_i[SEL_W-1:0];
        wlanes_o = {LANES{wdata_i[LANE_W-1:0]}};
        sel_o    = haddr_i[SEL_W-1:0];
      end
    endcase
  end

endmodule

// File: rtl/sram_rd_steer.sv
module sram_rd_steer
  import sram_lane_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W = $clog2(LANES),
  localparam int DW    = LANES * LANE_W
) (
  input  logic [1:0]       org_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] gated;

  // unselected lanes float on the board: never pass them through
  for (genvar i = 0; i < LANES; i++) begin : g_gate
    assign gated[i*LANE_W +: LANE_W] = mask_i[i] ? dq_i[i*LANE_W +: LANE_W] : '0;
  end

  always_comb begin
    rdata_o = '0;
    case (org_i)
      ORG_X32: rdata_o = gated;
      ORG_X16: rdata_o[DW/2-1:0] = sel_i[0] ? gated[DW-1:DW/2] : gated[DW/2-1:0];
      default: rdata_o[LANE_W-1:0] = gated[sel_i*LANE_W +: LANE_W];
    endcase
  end

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_lane_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 4,
  parameter int READ_CYC  = 5,
  parameter int TURN_CYC  = 3,
  localparam int MAX_A    = (SETUP_CYC > WE_CYC) ? SETUP_CYC : WE_CYC,
  localparam int MAX_CYC  = (MAX_A > READ_CYC) ? MAX_A : READ_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 2),
  localparam int TURN_W   = $clog2(TURN_CYC + 2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [LANES-1:0] mask_i,
  output logic             accept_o,
  output logic             rd_cap_o,
  output logic             ack_o,
  output logic [LANES-1:0] ce_no,
  output logic [LANES-1:0] we_no,
  output logic             oe_no,
  output logic [LANES-1:0] dq_oe_o
);

  phase_e            state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TURN_W-1:0] turn_q;
  logic              ack_q;

  assign accept_o = (state_q == PH_IDLE) && req_i;
  assign rd_cap_o = (state_q == PH_RD) && (cnt_q == '0);
  assign ack_o    = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      turn_q  <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      if (turn_q != '0) turn_q <= turn_q - 1'b1;
      case (state_q)
        PH_IDLE: if (req_i) begin
          if (!wr_i) begin
            state_q <= PH_RD;
            cnt_q   <= CNT_W'(READ_CYC - 1);
          end else if (turn_q == '0) begin
            state_q <= PH_WSET;
            cnt_q   <= CNT_W'(SETUP_CYC - 1);
          end else begin
            state_q <= PH_WAIT;
          end
        end
        PH_WAIT: if (turn_q == '0) begin
          state_q <= PH_WSET;
          cnt_q   <= CNT_W'(SETUP_CYC - 1);
        end
        PH_WSET: begin
          if (cnt_q == '0) begin
            state_q <= PH_WSTB;
            cnt_q   <= CNT_W'(WE_CYC - 1);
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_WSTB: begin
          if (cnt_q == '0) begin
            state_q <= PH_IDLE;
            ack_q   <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_RD: begin
          if (cnt_q == '0) begin
            state_q <= PH_IDLE;
            ack_q   <= 1'b1;
            turn_q  <= TURN_W'(TURN_CYC);
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  logic sel_act, strobe_act;
  assign sel_act    = (state_q == PH_WSET) || (state_q == PH_WSTB) || (state_q == PH_RD);
  assign strobe_act = (state_q == PH_WSTB);

  assign ce_no   = sel_act    ? ~mask_i : '1;
  assign we_no   = strobe_act ? ~mask_i : '1;
  assign dq_oe_o = strobe_act ?  mask_i : '0;
  assign oe_no   = (state_q != PH_RD);

  // checker state
  logic [CNT_W-1:0]  we_run_q;
  logic [TURN_W-1:0] rd_gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_run_q <= '0;
      rd_gap_q <= TURN_W'(TURN_CYC);
    end else begin
      we_run_q <= (&we_no) ? '0 : we_run_q + 1'b1;
      if (!oe_no) rd_gap_q <= '0;
      else if (rd_gap_q < TURN_W'(TURN_CYC)) rd_gap_q <= rd_gap_q + 1'b1;
    end
  end

  a_r2_ce_leads_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|(~we_no)) && !$past(|(~we_no))) |-> ($past(ce_no) == ce_no));

  a_r2_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&we_no) && !$past(&we_no)) |-> (we_run_q == CNT_W'(WE_CYC)));

  a_r3_drive_under_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|dq_oe_o) |-> ((dq_oe_o & we_no) == '0));

  a_r4_oe_excludes_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_no |-> (&we_no) && (dq_oe_o == '0));

  a_r5_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|dq_oe_o) && !$past(|dq_oe_o)) |-> (rd_gap_q >= TURN_W'(TURN_CYC)));

  a_r2_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int AW        = 17,
  parameter int LANES     = 4,
  parameter int LANE_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 4,
  parameter int READ_CYC  = 5,
  parameter int TURN_CYC  = 3,
  localparam int SEL_W    = $clog2(LANES),
  localparam int HAW      = AW + SEL_W,
  localparam int DW       = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [1:0]       org_i,
  input  logic [HAW-1:0]   addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ack_o,
  output logic [DW-1:0]    rdata_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [LANES-1:0] mem_ce_no,
  output logic [LANES-1:0] mem_we_no,
  output logic             mem_oe_no,
  output logic [DW-1:0]    mem_dq_o,
  output logic [LANES-1:0] mem_dq_oe_o,
  input  logic [DW-1:0]    mem_dq_i
);

  logic [AW-1:0]    map_addr;
  logic [LANES-1:0] map_mask;
  logic [DW-1:0]    map_wlanes;
  logic [SEL_W-1:0] map_sel;

  sram_addr_map #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_map (
    .org_i    (org_i),
    .haddr_i  (addr_i),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .waddr_o  (map_addr),
    .mask_o   (map_mask),
    .wlanes_o (map_wlanes),
    .sel_o    (map_sel)
  );

  logic             accept, rd_cap;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    wl_q;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       org_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      mask_q <= '0;
      wl_q   <= '0;
      sel_q  <= '0;
      org_q  <= '0;
    end else if (accept) begin
      addr_q <= map_addr;
      mask_q <= map_mask;
      wl_q   <= map_wlanes;
      sel_q  <= map_sel;
      org_q  <= org_i;
    end
  end

  sram_phase_fsm #(
    .LANES(LANES), .SETUP_CYC(SETUP_CYC), .WE_CYC(WE_CYC),
    .READ_CYC(READ_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .wr_i     (wr_i),
    .mask_i   (mask_q),
    .accept_o (accept),
    .rd_cap_o (rd_cap),
    .ack_o    (ack_o),
    .ce_no    (mem_ce_no),
    .we_no    (mem_we_no),
    .oe_no    (mem_oe_no),
    .dq_oe_o  (mem_dq_oe_o)
  );

  logic [DW-1:0] steered;

  sram_rd_steer #(.LANES(LANES), .LANE_W(LANE_W)) u_steer (
    .org_i   (org_q),
    .sel_i   (sel_q),
    .mask_i  (mask_q),
    .dq_i    (mem_dq_i),
    .rdata_o (steered)
  );

  logic [DW-1:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_cap) rdata_q <= steered;
  end

  assign rdata_o    = rdata_q;
  assign mem_addr_o = addr_q;
  assign mem_dq_o   = wl_q;

  a_r9_standby_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_ce_no != '1) |-> ((~mem_ce_no & ~mask_q) == '0));

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [1:0]  org = 2'b00;
  logic [18:0] addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic        ack;
  logic [31:0] rdata, dq_o, dq_i;
  logic [16:0] maddr;
  logic [3:0]  ce_n, we_n, dq_oe;
  logic        oe_n;

  always #2 clk = ~clk;

  sram_lane_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .org_i(org),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // memory model, 256 words
  logic [31:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always_comb
    for (int i = 0; i < 4; i++)
      dq_i[i*8 +: 8] = (!ce_n[i] && !oe_n) ? mem[maddr[7:0]][i*8 +: 8] : 8'hA5;

  int mon3 = 0, gap = 100, min_gap = 100, drv_starts = 0;
  logic [3:0] dq_oe_d = '0;
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++)
      if (!ce_n[i] && !we_n[i] && dq_oe[i]) mem[maddr[7:0]][i*8 +: 8] = dq_o[i*8 +: 8];
    if (rst_n) begin
      if (dq_oe != (~we_n)) mon3++;
      if (|dq_oe && !(|dq_oe_d)) begin
        drv_starts++;
        if (gap < min_gap) min_gap = gap;
      end
      if (!oe_n) gap = 0; else if (gap < 100) gap++;
    end
    dq_oe_d = dq_oe;
  end

  int nchk = 0, nerr = 0;
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [1:0] m, input logic [18:0] a,
                        input logic [3:0] b, input logic [31:0] d,
                        output logic [31:0] rd, output int setc, output int wec,
                        output int rdc, output logic [3:0] lanes, output logic [16:0] wa);
    int n;
    setc = 0; wec = 0; rdc = 0; lanes = '0; wa = '0; n = 0;
    req = 1'b1; wr = w; org = m; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0;
    while (!ack && n < 200) begin
      if (ce_n != 4'hF) begin
        lanes = ~ce_n;
        wa = maddr;
        if (&we_n && oe_n) setc++;
      end
      if (we_n != 4'hF) wec++;
      if (!oe_n) rdc++;
      @(negedge clk);
      n++;
    end
    chk(n < 200, "R2 ack timeout", 32'(n), 32'd0);
    chk(ce_n == 4'hF && we_n == 4'hF && oe_n && dq_oe == 4'h0, "R2 release at ack",
        {20'd0, ce_n, we_n, dq_oe}, 32'h0000_0FF0);
    rd = rdata;
  endtask

  function automatic logic [3:0] exp_lanes(logic [1:0] m, logic [18:0] a, logic [3:0] b);
    case (m)
      2'b00:   return b;
      2'b01:   return a[0] ? {b[1:0], 2'b00} : {2'b00, b[1:0]};
      default: return 4'(b[0]) << a[1:0];
    endcase
  endfunction

  function automatic logic [16:0] exp_waddr(logic [1:0] m, logic [18:0] a);
    case (m)
      2'b00:   return a[16:0];
      2'b01:   return a[17:1];
      default: return a[18:2];
    endcase
  endfunction

  // {wr, org, addr, be, wdata, expected read}
  localparam int NV = 13;
  localparam logic [89:0] VEC [NV] = '{
    {1'b1, 2'b00, 19'h00010, 4'hF, 32'h1122_3344, 32'h0},          // R6
    {1'b0, 2'b00, 19'h00010, 4'hF, 32'h0,         32'h1122_3344},  // R6
    {1'b0, 2'b00, 19'h00010, 4'h5, 32'h0,         32'h0022_0044},  // R9
    {1'b1, 2'b01, 19'h00021, 4'h3, 32'h0000_AABB, 32'h0},          // R7, R5
    {1'b0, 2'b00, 19'h00010, 4'hF, 32'h0,         32'hAABB_3344},  // R7
    {1'b0, 2'b01, 19'h00020, 4'h3, 32'h0,         32'h0000_3344},  // R7
    {1'b0, 2'b01, 19'h00021, 4'h2, 32'h0,         32'h0000_AA00},  // R7, R9
    {1'b1, 2'b10, 19'h00041, 4'h1, 32'h0000_00CC, 32'h0},          // R8
    {1'b0, 2'b10, 19'h00043, 4'h1, 32'h0,         32'h0000_00AA},  // R8
    {1'b0, 2'b10, 19'h00041, 4'h1, 32'h0,         32'h0000_00CC},  // R8
    {1'b1, 2'b10, 19'h00042, 4'h0, 32'h0000_00EE, 32'h0},          // R9
    {1'b0, 2'b00, 19'h00010, 4'hF, 32'h0,         32'hAABB_CC44},  // R9
    {1'b0, 2'b11, 19'h00040, 4'h1, 32'h0,         32'h0000_0044}   // R8
  };

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  ln;
    logic [16:0] wa;
    int sc, wc, rc, acks;

    repeat (3) @(negedge clk);
    chk(ce_n == 4'hF && we_n == 4'hF && oe_n && dq_oe == 0 && !ack, "R1 in reset",
        {19'd0, ce_n, we_n, oe_n, dq_oe}, 32'h0000_1FF0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(ce_n == 4'hF && we_n == 4'hF && oe_n && dq_oe == 0 && !ack, "R1 after reset",
        {19'd0, ce_n, we_n, oe_n, dq_oe}, 32'h0000_1FF0);

    for (int v = 0; v < NV; v++) begin
      logic [89:0] t;
      logic [3:0]  el;
      t  = VEC[v];
      el = exp_lanes(t[88:87], t[86:68], t[67:64]);
      access(t[89], t[88:87], t[86:68], t[67:64], t[63:32], rd, sc, wc, rc, ln, wa);
      chk(ln == el, "R6/R7/R8/R9 lanes", 32'(ln), 32'(el));
      if (el != 0)
        chk(wa == exp_waddr(t[88:87], t[86:68]), "R6/R7/R8 word address",
            32'(wa), 32'(exp_waddr(t[88:87], t[86:68])));
      if (t[89]) begin
        if (el != 0) begin
          chk(sc == 1, "R2 setup cycles", 32'(sc), 32'd1);
          chk(wc == 4, "R2 strobe cycles", 32'(wc), 32'd4);
        end
        chk(rc == 0, "R2 no oe during write", 32'(rc), 32'd0);
      end else begin
        chk(rc == 5, "R4 read cycles", 32'(rc), 32'd5);
        chk(wc == 0, "R4 no we during read", 32'(wc), 32'd0);
        chk(rd == t[31:0], "R4/R6/R7/R8/R9 read data", rd, t[31:0]);
      end
    end

    // R10: a write request during a read is dropped
    req = 1'b1; wr = 1'b0; org = 2'b00; addr = 19'h00010; be = 4'hF;
    @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    req = 1'b1; wr = 1'b1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    req = 1'b0;
    acks = 0;
    for (int c = 0; c < 20; c++) begin
      if (ack) acks++;
      @(negedge clk);
    end
    chk(acks == 1, "R10 single ack", 32'(acks), 32'd1);
    access(1'b0, 2'b00, 19'h00010, 4'hF, 32'h0, rd, sc, wc, rc, ln, wa);
    chk(rd == 32'hAABB_CC44, "R10 memory unchanged", rd, 32'hAABB_CC44);

    chk(mon3 == 0, "R3 driver tracks we", 32'(mon3), 32'd0);
    chk(drv_starts > 0 && min_gap >= 3, "R5 turnaround gap", 32'(min_gap), 32'd3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

endmodule